// File: doc/BRIEF.md
# Dual-Bank Exchangeable Register File

This block holds the eight byte-wide working registers of a small processor datapath: an accumulator A with its flag byte F, and the general registers B, C, D, E, H and L. The registers are grouped into four 16-bit pairs: AF, BC, DE and HL. Every pair has two physical copies, a main copy and an alternate copy. At any time only one copy of each pair can be reached from the ports.

Two exchange commands choose which copy is visible. The first command changes the copy for AF only. The second changes the copy for BC, DE and HL together. Each command flips a bank-select bit, so an exchange moves no data and takes one clock. The two bank-select bits are independent, which gives four possible mappings.

The read ports and the write port always address the active copy. There are two byte-wide read ports and one pair-wide read port, all combinational. The single write port writes either one byte or a whole pair.

Top module: `xreg_file`

## Requirements
- R1: Synchronous active-low reset sets both bank-select outputs to 0 (main set active) and clears all sixteen stored bytes in both copies to 0x00.
- R2: Byte selection uses this 3-bit code: 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=A, 7=F. A byte write (wr_en_i=1, wr_pair_i=0) stores wr_data_i[7:0] into the register that wr_sel_i names. No other byte changes.
- R3: Pairs are indexed 0=BC, 1=DE, 2=HL, 3=AF, and the first-named register is bits [15:8]. A pair write (wr_en_i=1, wr_pair_i=1) takes the pair index from wr_sel_i[2:1] and ignores wr_sel_i[0]. It stores wr_data_i[15:8] in the high register and wr_data_i[7:0] in the low register.
- R4: Both byte read ports and the pair read port return the active copy of the selected register or pair, combinationally. The byte ports use the R2 code and the pair port uses the R3 index.
- R5: A clock with xchg_acc_i=1 switches the active copy of AF and does not change which copy of BC, DE and HL is visible.
- R6: A clock with xchg_gen_i=1 switches the active copies of BC, DE and HL together and does not change which copy of AF is visible.
- R7: Issuing the same exchange command on two clocks restores the original mapping and the original visible contents.
- R8: If a write and an exchange occur in the same clock, the write lands in the copy that was active before that clock's exchange.
- R9: Both exchange commands in the same clock switch both bank selects. All four combinations of the two bank selects can be reached.
- R10: acc_bank_o and gen_bank_o show the AF and general bank selects: 0 means the main copy and 1 means the alternate copy.
- R11: A copy that is not active keeps its contents unchanged through any writes, and shows them again once it is swapped back in.
- R12: F stores all eight bits, so the spare flag positions 5 and 3 read back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xchg_acc_i | input | 1 | Switch the active copy of AF |
| xchg_gen_i | input | 1 | Switch the active copies of BC, DE and HL |
| wr_en_i | input | 1 | Write enable |
| wr_pair_i | input | 1 | 1 = pair write, 0 = byte write |
| wr_sel_i | input | 3 | Byte code (R2); bits [2:1] give the pair index in pair mode |
| wr_data_i | input | 16 | Write data; only [7:0] is used for a byte write |
| rd_a_sel_i | input | 3 | Byte code for read port A |
| rd_a_data_o | output | 8 | Read port A data |
| rd_b_sel_i | input | 3 | Byte code for read port B |
| rd_b_data_o | output | 8 | Read port B data |
| rd_p_sel_i | input | 2 | Pair index for the pair read port |
| rd_p_data_o | output | 16 | Pair read port data |
| acc_bank_o | output | 1 | Current AF bank select |
| gen_bank_o | output | 1 | Current general-pair bank select |

## Verification
The properties assume that every control input is driven to 0 or 1 on every clock after reset, and that reset is held low at time zero. Some properties also need particular input conditions. The pair-write property counts only clocks with no exchange. Each "pair kept" property counts only clocks with no write to the pair it watches.

The bench drives all control inputs from defined values on every clock. Its random stimulus enables exchanges and writes independently, so clocks that meet each property's conditions occur often. Directed sequences cover the clocks where a write and an exchange coincide.

// File: rtl/xreg_pkg.sv
// Shared codes for the exchangeable register file.
// Assumes byte codes pair up as {pair index, low-byte bit}.
package xreg_pkg;
    localparam int NPAIR   = 4;
    localparam int PAIR_AF = 3;

    typedef enum logic [2:0] {
        SEL_B = 3'd0, SEL_C = 3'd1, SEL_D = 3'd2, SEL_E = 3'd3,
        SEL_H = 3'd4, SEL_L = 3'd5, SEL_A = 3'd6, SEL_F = 3'd7
    } byte_sel_e;

    typedef enum logic [1:0] {
        PR_BC = 2'd0, PR_DE = 2'd1, PR_HL = 2'd2, PR_AF = 2'd3
    } pair_sel_e;
endpackage

// File: rtl/xreg_bank_sel.sv
// Bank-select flip-flop: toggles on each exchange request.
// Assumes a synchronous active-low reset that selects the main bank.
module xreg_bank_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic flip_i,
    output logic bank_o
);
    // Hold or invert the select on each clock.
    always_ff @(posedge clk) begin
        if (!rst_n)      bank_o <= 1'b0;
        else if (flip_i) bank_o <= ~bank_o;
    end
endmodule

// File: rtl/xreg_pair_store.sv
// One register pair with a main and an alternate copy.
// Writes go to the copy named by bank_i, which is the select value
// before any toggle in the same clock. The output shows that copy.
module xreg_pair_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bank_i,
    input  logic         we_hi_i,
    input  logic         we_lo_i,
    input  logic [W-1:0] d_hi_i,
    input  logic [W-1:0] d_lo_i,
    output logic [2*W-1:0] q_o
);
    logic [W-1:0] hi_q [2];
    logic [W-1:0] lo_q [2];

    // Byte-granular storage of both copies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++) begin
                hi_q[b] <= '0;
                lo_q[b] <= '0;
            end
        end else begin
            if (we_hi_i) hi_q[bank_i] <= d_hi_i;
            if (we_lo_i) lo_q[bank_i] <= d_lo_i;
        end
    end

    // Present the active copy.
    assign q_o = {hi_q[bank_i], lo_q[bank_i]};
endmodule

// File: rtl/xreg_read_mux.sv
// Read selection: two byte ports and one pair port.
// Assumes byte code = {pair index, low-byte bit}, with high byte in [2W-1:W].
module xreg_read_mux #(
    parameter int W     = 8,
    parameter int NPAIR = 4
) (
    input  logic [NPAIR-1:0][2*W-1:0] act_i,
    input  logic [2:0]                sel_a_i,
    input  logic [2:0]                sel_b_i,
    input  logic [1:0]                sel_p_i,
    output logic [W-1:0]              a_o,
    output logic [W-1:0]              b_o,
    output logic [2*W-1:0]            p_o
);
    logic [2:0]   bsel [2];
    logic [W-1:0] bout [2];

    assign bsel[0] = sel_a_i;
    assign bsel[1] = sel_b_i;

    for (genvar k = 0; k < 2; k++) begin : g_byte
        // Pick the pair, then its high or low byte.
        always_comb begin
            if (bsel[k][0]) bout[k] = act_i[bsel[k][2:1]][W-1:0];
            else            bout[k] = act_i[bsel[k][2:1]][2*W-1:W];
        end
    end

    assign a_o = bout[0];
    assign b_o = bout[1];
    assign p_o = act_i[sel_p_i];
endmodule

// File: rtl/xreg_file.sv
// Dual-bank register file with separate AF and general-pair exchange.
// Assumes the caller decodes exchange and write commands. A write and
// an exchange in one clock target the bank active before that clock.
module xreg_file #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xchg_acc_i,
    input  logic                xchg_gen_i,
    input  logic                wr_en_i,
    input  logic                wr_pair_i,
    input  logic [2:0]          wr_sel_i,
    input  logic [2*BYTE_W-1:0] wr_data_i,
    input  logic [2:0]          rd_a_sel_i,
    output logic [BYTE_W-1:0]   rd_a_data_o,
    input  logic [2:0]          rd_b_sel_i,
    output logic [BYTE_W-1:0]   rd_b_data_o,
    input  logic [1:0]          rd_p_sel_i,
    output logic [2*BYTE_W-1:0] rd_p_data_o,
    output logic                acc_bank_o,
    output logic                gen_bank_o
);
    import xreg_pkg::*;

    localparam int PAIR_W = 2 * BYTE_W;

    logic [NPAIR-1:0][PAIR_W-1:0] act_q;

    xreg_bank_sel u_acc_sel (
        .clk(clk), .rst_n(rst_n), .flip_i(xchg_acc_i), .bank_o(acc_bank_o)
    );
    xreg_bank_sel u_gen_sel (
        .clk(clk), .rst_n(rst_n), .flip_i(xchg_gen_i), .bank_o(gen_bank_o)
    );

    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
        logic hit, we_hi, we_lo, bank;
        logic [BYTE_W-1:0] d_hi;

        // Write decode for this pair.
        always_comb begin
            hit   = wr_en_i && (wr_sel_i[2:1] == 2'(i));
            we_hi = hit && (wr_pair_i || !wr_sel_i[0]);
            we_lo = hit && (wr_pair_i ||  wr_sel_i[0]);
            d_hi  = wr_pair_i ? wr_data_i[PAIR_W-1:BYTE_W] : wr_data_i[BYTE_W-1:0];
            bank  = (i == PAIR_AF) ? acc_bank_o : gen_bank_o;
        end

        xreg_pair_store #(.W(BYTE_W)) u_store (
            .clk(clk), .rst_n(rst_n), .bank_i(bank),
            .we_hi_i(we_hi), .we_lo_i(we_lo),
            .d_hi_i(d_hi), .d_lo_i(wr_data_i[BYTE_W-1:0]),
            .q_o(act_q[i])
        );
    end

    xreg_read_mux #(.W(BYTE_W), .NPAIR(NPAIR)) u_rd (
        .act_i(act_q), .sel_a_i(rd_a_sel_i), .sel_b_i(rd_b_sel_i),
        .sel_p_i(rd_p_sel_i), .a_o(rd_a_data_o), .b_o(rd_b_data_o),
        .p_o(rd_p_data_o)
    );
endmodule

// File: rtl/xreg_file_sva.sv
// Checker for xreg_file, attached with bind. Watches the bank selects
// and the active pair values that the storage drives.
module xreg_file_sva #(
    parameter int BYTE_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      xchg_acc_i,
    input logic                      xchg_gen_i,
    input logic                      wr_en_i,
    input logic                      wr_pair_i,
    input logic [2:0]                wr_sel_i,
    input logic [2*BYTE_W-1:0]       wr_data_i,
    input logic                      acc_bank_o,
    input logic                      gen_bank_o,
    input logic [3:0][2*BYTE_W-1:0]  act_q
);
    // R1: reset selects the main copies
    p_reset_main_r1: assert property (@(posedge clk)
        !rst_n |=> (!acc_bank_o && !gen_bank_o));

    // R5: an AF exchange flips the AF select
    p_acc_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xchg_acc_i |=> (acc_bank_o != $past(acc_bank_o)));

    // R5: without an AF exchange the AF select holds
    p_acc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !xchg_acc_i |=> $stable(acc_bank_o));

    // R6: a general exchange flips the general select
    p_gen_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xchg_gen_i |=> (gen_bank_o != $past(gen_bank_o)));

    // R6: without a general exchange the general select holds
    p_gen_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !xchg_gen_i |=> $stable(gen_bank_o));

    // R6: a general exchange leaves the visible AF untouched
    p_af_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_gen_i && !xchg_acc_i && !(wr_en_i && wr_sel_i[2:1] == 2'd3))
        |=> $stable(act_q[3]));

    // R5: an AF exchange leaves the visible BC untouched
    p_bc_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_acc_i && !xchg_gen_i && !(wr_en_i && wr_sel_i[2:1] == 2'd0))
        |=> $stable(act_q[0]));

    // R3: a pair write without an exchange is visible on the next clock
    p_pair_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_pair_i && !xchg_acc_i && !xchg_gen_i)
        |=> (act_q[$past(wr_sel_i[2:1])] == $past(wr_data_i)));
endmodule

bind xreg_file xreg_file_sva #(.BYTE_W(BYTE_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .xchg_acc_i(xchg_acc_i), .xchg_gen_i(xchg_gen_i),
    .wr_en_i(wr_en_i), .wr_pair_i(wr_pair_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .acc_bank_o(acc_bank_o), .gen_bank_o(gen_bank_o),
    .act_q(act_q)
);

// File: tb/xreg_file_tb_top.sv
`timescale 1ns/1ps
module xreg_file_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xchg_acc = 1'b0, xchg_gen = 1'b0, wr_en = 1'b0, wr_pair = 1'b0;
    logic [2:0]  wr_sel = '0, ra = '0, rb = '0;
    logic [1:0]  rp = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  a_d, b_d;
    logic [15:0] p_d;
    logic        ab_o, gb_o;

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model: [bank][byte code]
    logic [7:0] mdl [2][8];
    bit ab = 0, gb = 0;

    always #2.5 clk = ~clk;

    xreg_file dut_i (
        .clk(clk), .rst_n(rst_n), .xchg_acc_i(xchg_acc), .xchg_gen_i(xchg_gen),
        .wr_en_i(wr_en), .wr_pair_i(wr_pair), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .rd_a_sel_i(ra), .rd_a_data_o(a_d), .rd_b_sel_i(rb), .rd_b_data_o(b_d),
        .rd_p_sel_i(rp), .rd_p_data_o(p_d), .acc_bank_o(ab_o), .gen_bank_o(gb_o)
    );

    function automatic bit bank_of(int c);
        return (c >= 6) ? ab : gb;
    endfunction

    function automatic logic [7:0] exp_byte(int c);
        return mdl[bank_of(c)][c];
    endfunction

    task automatic chk(string tag, string what, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Apply one clock of stimulus, update the model, then check the ports.
    task automatic step(string tag, bit en, bit pr, logic [2:0] sel, logic [15:0] d,
                        bit xa, bit xg, logic [2:0] sa, logic [2:0] sb, logic [1:0] sp);
        @(negedge clk);
        wr_en = en; wr_pair = pr; wr_sel = sel; wr_data = d;
        xchg_acc = xa; xchg_gen = xg; ra = sa; rb = sb; rp = sp;
        @(posedge clk);
        if (en) begin
            if (pr) begin
                mdl[bank_of({sel[2:1], 1'b0})][{sel[2:1], 1'b0}] = d[15:8];
                mdl[bank_of({sel[2:1], 1'b1})][{sel[2:1], 1'b1}] = d[7:0];
            end else begin
                mdl[bank_of(sel)][sel] = d[7:0];
            end
        end
        if (xa) ab = ~ab;
        if (xg) gb = ~gb;
        #1;
        chk(tag, "read A", {8'h0, a_d}, {8'h0, exp_byte(sa)});
        chk(tag, "read B", {8'h0, b_d}, {8'h0, exp_byte(sb)});
        chk(tag, "read pair", p_d, {exp_byte(2*sp), exp_byte(2*sp+1)});
        chk("R10", "acc bank", {15'h0, ab_o}, {15'h0, ab});
        chk("R10", "gen bank", {15'h0, gb_o}, {15'h0, gb});
    endtask

    task automatic idle_read(string tag, logic [2:0] sa, logic [2:0] sb, logic [1:0] sp);
        step(tag, 0, 0, 3'd0, 16'h0, 0, 0, sa, sb, sp);
    endtask

    initial begin : watchdog
        #(200000 * 5.0);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5EED_1234));
        for (int b = 0; b < 2; b++)
            for (int c = 0; c < 8; c++) mdl[b][c] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state of every byte and both selects
        for (int c = 0; c < 8; c++) idle_read("R1", 3'(c), 3'(7 - c), 2'(c % 4));

        // R2: byte writes to each code, read back
        for (int c = 0; c < 8; c++)
            step("R2", 1, 0, 3'(c), {8'hEE, 8'(8'h11 * (c + 1))}, 0, 0, 3'(c), 3'(c ^ 1), 2'(c >> 1));

        // R3: pair writes with wr_sel[0] set (ignored in pair mode)
        for (int p = 0; p < 4; p++)
            step("R3", 1, 1, {2'(p), 1'b1}, 16'hA050 + 16'(p * 16'h0101), 0, 0,
                 {2'(p), 1'b0}, {2'(p), 1'b1}, 2'(p));

        // R12: spare flag bits 5 and 3 kept
        step("R12", 1, 0, 3'd7, 16'h0028, 0, 0, 3'd7, 3'd6, 2'd3);
        step("R12", 1, 0, 3'd7, 16'h00D7, 0, 0, 3'd7, 3'd7, 2'd3);

        // R5: AF exchange exposes the alternate AF, BC stays
        step("R5", 0, 0, 3'd0, 16'h0, 1, 0, 3'd6, 3'd0, 2'd3);
        idle_read("R5", 3'd1, 3'd7, 2'd0);

        // R11: write into the alternate AF, swap back, main AF reappears
        step("R11", 1, 1, 3'd6, 16'h1234, 0, 0, 3'd6, 3'd7, 2'd3);
        step("R7", 0, 0, 3'd0, 16'h0, 1, 0, 3'd6, 3'd7, 2'd3);
        idle_read("R11", 3'd6, 3'd7, 2'd3);

        // R6: general exchange swaps BC, DE and HL, AF stays
        step("R6", 0, 0, 3'd0, 16'h0, 0, 1, 3'd0, 3'd6, 2'd2);
        idle_read("R6", 3'd3, 3'd5, 2'd1);
        idle_read("R6", 3'd4, 3'd7, 2'd3);

        // R8: write and exchange in the same clock hit the pre-swap bank
        step("R8", 1, 1, 3'd2, 16'hBEEF, 0, 1, 3'd2, 3'd3, 2'd1);
        step("R8", 0, 0, 3'd0, 16'h0, 0, 1, 3'd2, 3'd3, 2'd1);
        step("R8", 1, 0, 3'd6, 16'h0077, 1, 0, 3'd6, 3'd7, 2'd3);
        step("R7", 0, 0, 3'd0, 16'h0, 1, 0, 3'd6, 3'd7, 2'd3);

        // R9: both exchanges in one clock, walk through all four mappings
        step("R9", 0, 0, 3'd0, 16'h0, 1, 1, 3'd0, 3'd6, 2'd3);
        step("R9", 0, 0, 3'd0, 16'h0, 1, 0, 3'd2, 3'd7, 2'd0);
        step("R9", 0, 0, 3'd0, 16'h0, 1, 1, 3'd4, 3'd6, 2'd2);
        step("R9", 0, 0, 3'd0, 16'h0, 0, 1, 3'd5, 3'd7, 2'd1);

        // R4: random mix of writes, exchanges and reads
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            step("R4", r[0] | r[1], r[2], r[5:3], 16'($urandom),
                 (r[9:6] == 4'd0), (r[13:10] == 4'd0),
                 r[16:14], r[19:17], r[21:20]);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule